// File: doc/BRIEF.md
# Shift and Permute Unit

This block is a 32-bit execution unit for shift and bit-permutation operations. It does logical shifts in both directions, arithmetic right shift and ones-filling shifts in both directions. It also does rotates in both directions, a full bit mirror, a byte-order swap, and a per-byte OR-combine. The only shifting hardware is one right shifter. Any operation that moves bits toward the top mirrors the operand first, shifts it right, and mirrors the result back.

The shifter takes a double-width input. The low half is the operand and the high half is the fill word. The fill word is all zeros, all ones, the sign bit repeated, or the operand itself for a rotate. This lets one logarithmic structure serve every shift flavour.

The caller presents an operation code, an operand and a 7-bit amount field with a valid strobe. The unit uses only the low five bits of the amount. The registered result appears one clock later with its own valid flag.

Top module: `shperm_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `result` is 0 until the first accepted operation.
- R2: An operation presented with `in_valid` high appears on `result` with `out_valid` high exactly one clock later. When `in_valid` is low, `out_valid` goes low on the next clock and `result` keeps its previous value.
- R3: Op 0 (shift left) and op 1 (shift right) move the operand by the amount and fill vacated positions with zeros.
- R4: Op 2 (arithmetic right shift) fills vacated positions with the operand's bit 31.
- R5: Op 3 (ones-fill left) and op 4 (ones-fill right) behave like ops 0 and 1 but fill vacated positions with ones.
- R6: Op 5 (rotate left) and op 6 (rotate right) are circular. Bits leaving one end re-enter at the other.
- R7: Op 7 mirrors the operand: result bit i equals operand bit 31-i. The amount is ignored.
- R8: Op 8 swaps byte order: result byte k equals operand byte 3-k. The amount is ignored.
- R9: Op 9 sets each result byte to 0xFF if the matching operand byte is nonzero, and to 0x00 otherwise.
- R10: Amount bits 6 and 5 have no effect on any result.
- R11: For ops 0 to 6, an effective amount of zero returns the operand unchanged.
- R12: Op codes 10 to 15 produce a result of 0, still with `out_valid` high one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (see requirements) |
| operand | input | 32 | Source value |
| amount | input | 7 | Amount field; only bits 4:0 are used |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 32 | Registered result |

## Verification
The risky coincidence is operand mirroring combined with a non-zero fill word in the same cycle. A ones-fill left shift or a rotate left must mirror the operand, fill from the correct end and mirror the result back, all at once. A fault in the ordering shows up only when both are active.

The bench sweeps every operation against every effective amount over several operand patterns. The unused upper amount bits are set to varying values throughout. Each result is compared with an arithmetic model written from shift, rotate and byte formulas.

// File: rtl/shperm_pkg.sv
package shperm_pkg;
    typedef enum logic [3:0] {
        OP_SHL   = 4'd0,
        OP_SHR   = 4'd1,
        OP_SAR   = 4'd2,
        OP_SHL1  = 4'd3,
        OP_SHR1  = 4'd4,
        OP_ROTL  = 4'd5,
        OP_ROTR  = 4'd6,
        OP_MIRR  = 4'd7,
        OP_BSWAP = 4'd8,
        OP_BORC  = 4'd9
    } shperm_op_e;
endpackage

// File: rtl/shperm_mirror.sv
module shperm_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/shperm_rshift.sv
module shperm_rshift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         fill,
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         dout
);
    localparam int SH_W = $clog2(W);
    localparam int CAT_W = 2 * W;

    logic [CAT_W-1:0] stage [SH_W+1];
    logic [W-1:0]     top_unused;

    assign stage[0] = {fill, din};
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
    end
    assign {top_unused, dout} = stage[SH_W];
endmodule

// File: rtl/shperm_bytes.sv
module shperm_bytes #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] swapped,
    output logic [W-1:0] orcomb
);
    localparam int NB = W / 8;
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign swapped[8*b +: 8] = din[8*(NB-1-b) +: 8];
        assign orcomb[8*b +: 8]  = {8{|din[8*b +: 8]}};
    end
endmodule

// File: rtl/shperm_unit.sv
module shperm_unit
    import shperm_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amount,
    output logic             out_valid,
    output logic [WIDTH-1:0] result
);
    localparam int SH_W = $clog2(WIDTH);
    localparam int NB   = WIDTH / 8;

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } state_t;

    state_t state_d, state_q;

    shperm_op_e       op_sel;
    logic             go_left;
    logic             flip_back;
    logic [WIDTH-1:0] op_mirr;
    logic [WIDTH-1:0] sh_src;
    logic [WIDTH-1:0] sh_fill;
    logic [SH_W-1:0]  sh_amt;
    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] sh_mirr;
    logic [WIDTH-1:0] by_swap;
    logic [WIDTH-1:0] by_orc;
    logic             amt_unused;

    assign op_sel     = shperm_op_e'(op);
    assign amt_unused = ^amount[AMT_W-1:SH_W];

    shperm_mirror #(.W(WIDTH)) u_pre_mirror (
        .din  (operand),
        .dout (op_mirr)
    );

    shperm_rshift #(.W(WIDTH)) u_shifter (
        .fill (sh_fill),
        .din  (sh_src),
        .amt  (sh_amt),
        .dout (sh_out)
    );

    shperm_mirror #(.W(WIDTH)) u_post_mirror (
        .din  (sh_out),
        .dout (sh_mirr)
    );

    shperm_bytes #(.W(WIDTH)) u_bytes (
        .din     (operand),
        .swapped (by_swap),
        .orcomb  (by_orc)
    );

    always_comb begin
        go_left   = (op_sel == OP_SHL) || (op_sel == OP_SHL1) ||
                    (op_sel == OP_ROTL) || (op_sel == OP_MIRR);
        flip_back = go_left && (op_sel != OP_MIRR);
        sh_src    = go_left ? op_mirr : operand;
        sh_amt    = (op_sel == OP_MIRR) ? '0 : amount[SH_W-1:0];
        unique case (op_sel)
            OP_SAR:            sh_fill = {WIDTH{operand[WIDTH-1]}};
            OP_SHL1, OP_SHR1:  sh_fill = '1;
            OP_ROTL, OP_ROTR:  sh_fill = sh_src;
            default:           sh_fill = '0;
        endcase
    end

    always_comb begin
        logic [WIDTH-1:0] res;
        unique case (op_sel)
            OP_SHL, OP_SHR, OP_SAR, OP_SHL1, OP_SHR1,
            OP_ROTL, OP_ROTR, OP_MIRR:
                res = flip_back ? sh_mirr : sh_out;
            OP_BSWAP: res = by_swap;
            OP_BORC:  res = by_orc;
            default:  res = '0;
        endcase
        state_d.valid = in_valid;
        state_d.data  = in_valid ? res : state_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.data;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    // R11
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd6 && amount[SH_W-1:0] == '0)
        |=> (result == $past(operand)));
    // R6
    rot_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd5 || op == 4'd6 || op == 4'd7 || op == 4'd8))
        |=> ($countones(result) == $countones($past(operand))));
    // R12
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd9) |=> (result == '0));

    for (genvar b = 0; b < NB; b++) begin : g_orc_chk
        // R9
        orc_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 4'd9)
            |=> (result[8*b +: 8] == {8{|$past(operand[8*b +: 8])}}));
    end
endmodule

// File: tb/shperm_unit_test.sv
module shperm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] operand;
    logic [6:0]  amount;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    shperm_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .operand   (operand),
        .amount    (amount),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                          input logic [6:0] am);
        int a = int'(am[4:0]);
        logic [31:0] r;
        case (o)
            4'd0: r = x << a;
            4'd1: r = x >> a;
            4'd2: r = 32'($signed(x) >>> a);
            4'd3: r = ~((~x) << a);
            4'd4: r = ~((~x) >> a);
            4'd5: r = (a == 0) ? x : ((x << a) | (x >> (32 - a)));
            4'd6: r = (a == 0) ? x : ((x >> a) | (x << (32 - a)));
            4'd7: for (int i = 0; i < 32; i++) r[i] = x[31-i];
            4'd8: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
            4'd9: for (int k = 0; k < 4; k++) r[8*k +: 8] = (x[8*k +: 8] != 0) ? 8'hFF : 8'h00;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [3:0] o, input logic [6:0] am);
        if (o <= 4'd6 && am[4:0] == 0) return "R11";
        if (am[6:5] != 0 && o <= 4'd6) return "R10";
        case (o)
            4'd0, 4'd1: return "R3";
            4'd2:       return "R4";
            4'd3, 4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7:       return "R7";
            4'd8:       return "R8";
            4'd9:       return "R9";
            default:    return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [3:0] o, input logic [31:0] x, input logic [6:0] am);
        logic [31:0] e = model(o, x, am);
        @(negedge clk);
        in_valid = 1'b1; op = o; operand = x; amount = am;
        @(negedge clk);
        in_valid = 1'b0; operand = ~x; op = 4'd0; amount = 7'd3;
        check("R2 valid", {31'b0, out_valid}, 32'd1);
        check(tag(o, am), result, e);
        @(negedge clk);
        check("R2 hold", result, e);
        check("R2 drop", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        #(20 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [5];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h1234_5678;
        pats[2] = 32'hF0F0_00A5;
        pats[3] = 32'h7FFF_0000;
        pats[4] = 32'h00FF_0100;
        rst_n = 1'b0; in_valid = 1'b0; op = 4'd0; operand = 32'h0; amount = 7'd0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", {31'b0, out_valid}, 32'd0);
        check("R1 after result", result, 32'd0);
        for (int o = 0; o < 16; o++) begin
            for (int p = 0; p < 5; p++) begin
                for (int a = 0; a < 32; a++) begin
                    logic [6:0] am = {2'((a + p + o) % 4), 5'(a)};
                    run_one(4'(o), pats[p], am);
                    if (o > 9 && a > 1) break;
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule